// File: doc/BRIEF.md
# Two-Wire Serial EEPROM Write Controller

This block is the write half of a serial EEPROM that sits on a two-wire bus. It watches the clock and data lines, which are already synchronised to the system clock. It finds start and stop conditions and shifts in bytes MSB first. It acknowledges by pulling the data line low through an open-drain enable. A write transaction carries a device address byte with the direction bit clear, then the upper and lower bytes of the memory address, then one or more data bytes.

Data bytes are collected in an eight-entry page buffer. The buffer slot is chosen by the low three address bits, and only those bits step from one byte to the next. A stop that follows at least one complete, acknowledged data byte starts a self-timed write interval. During that interval the controller is busy and deaf to the bus. At the end of the interval the buffered bytes are copied into a register-array memory in a single cycle. A combinational read port lets neighbouring logic look at the memory contents.

Top module: `i2c_eeprom_wr`

## Requirements
- R1: A start is SDA falling while SCL is high and a stop is SDA rising while SCL is high. Bytes sent before the first start are not acknowledged.
- R2: The first byte after a start is the device byte: bits 7..1 hold the device address and bit 0 the direction. It is acknowledged only when bits 7..1 equal DEV_ADDR and bit 0 is 0. Otherwise it gets no acknowledge, and the rest of the transaction until the next start is neither acknowledged nor written.
- R3: The device byte, both memory address bytes and every data byte of an accepted write are acknowledged. `sda_pull_o` goes high after the falling SCL edge that ends bit 8 and drops after the falling SCL edge that ends the ninth clock. The line is never driven high.
- R4: The memory address arrives upper byte first, then lower byte. Its low MEM_AW bits select the location, and higher bits are ignored.
- R5: A stop after one data byte writes that byte at the received address and changes no other location.
- R6: Each further data byte goes to the next address with only bits 2..0 incremented. The address wraps inside the aligned 8-byte page.
- R7: When more than 8 data bytes arrive, later bytes overwrite earlier ones at the wrapped address. The last value for each location wins.
- R8: A stop after at least one complete, acknowledged data byte raises `busy_o` for exactly WR_CYCLES clock cycles. The memory keeps its old contents during that interval and holds the buffered bytes once it ends.
- R9: While `busy_o` is high, bus activity is ignored. Nothing is acknowledged, the memory is not changed and the interval is not extended.
- R10: A repeated start, or a stop arriving in the middle of a byte or its acknowledge, aborts the transaction without writing anything. A stop with no data byte starts no write interval.
- R11: After reset `busy_o` and `sda_pull_o` are low and every memory location reads 0.
- R12: `rd_data_o` shows the memory byte at `rd_addr_i` in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| scl_i | input | 1 | Synchronised bus clock level |
| sda_i | input | 1 | Synchronised bus data level |
| sda_pull_o | output | 1 | Open-drain enable, pulls SDA low when high |
| busy_o | output | 1 | Self-timed write interval in progress |
| rd_addr_i | input | MEM_AW | Memory read address |
| rd_data_o | output | 8 | Memory byte at `rd_addr_i` |

## Verification
The bench builds the block with DEV_ADDR = 7'h2C, MEM_AW = 9 and WR_CYCLES = 600. With a 9-bit address, bit 0 of the upper address byte selects the memory half, and the bits above it are ignored. Both of these can be seen on a small 512-byte array that the bench compares in full after each write. A 600-cycle write interval is longer than a complete one-byte transaction at the bench's bus speed. That lets a whole ignored write, from start to stop, fall inside a single busy interval.

// File: rtl/eew_pkg.sv
package eew_pkg;
  typedef enum logic [2:0] {
    ST_IDLE,
    ST_DEV,
    ST_AHI,
    ST_ALO,
    ST_DATA,
    ST_SKIP,
    ST_BUSY
  } eew_state_e;
endpackage

// File: rtl/eew_bus_cond.sv
module eew_bus_cond (
  input  logic clk,
  input  logic rst_n,
  input  logic scl_i,
  input  logic sda_i,
  output logic start_o,
  output logic stop_o,
  output logic rise_o,
  output logic fall_o
);
  logic scl_q, sda_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      scl_q <= 1'b1;
      sda_q <= 1'b1;
    end else begin
      scl_q <= scl_i;
      sda_q <= sda_i;
    end
  end

  assign start_o = scl_q & scl_i & sda_q & ~sda_i;
  assign stop_o  = scl_q & scl_i & ~sda_q & sda_i;
  assign rise_o  = scl_i & ~scl_q;
  assign fall_o  = ~scl_i & scl_q;

  // R1
  cond_level_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (start_o || stop_o) |-> (scl_i && $past(scl_i)));
endmodule

// File: rtl/eew_byte_rx.sv
module eew_byte_rx #(
  parameter int BW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          clr_i,
  input  logic          rise_i,
  input  logic          fall_i,
  input  logic          sda_i,
  input  logic          ack_req_i,
  output logic [BW-1:0] byte_o,
  output logic          done_o,
  output logic          boundary_o,
  output logic          pull_o
);
  localparam int CW = $clog2(BW + 2);
  localparam logic [CW-1:0] LAST = CW'(BW - 1);
  localparam logic [CW-1:0] ACKB = CW'(BW);
  localparam logic [CW-1:0] ACKE = CW'(BW + 1);

  logic [CW-1:0] cnt_q, cnt_d;
  logic [BW-2:0] sh_q, sh_d;
  logic          pend_q, pend_d;
  logic          pull_q, pull_d;

  always_comb begin
    cnt_d  = cnt_q;
    sh_d   = sh_q;
    pend_d = pend_q;
    pull_d = pull_q;
    if (clr_i) begin
      cnt_d  = '0;
      pend_d = 1'b0;
      pull_d = 1'b0;
    end else if (rise_i && (cnt_q < ACKB)) begin
      sh_d  = {sh_q[BW-3:0], sda_i};
      cnt_d = cnt_q + 1'b1;
      if (cnt_q == LAST) pend_d = ack_req_i;
    end else if (fall_i && (cnt_q == ACKB)) begin
      pull_d = pend_q;
      cnt_d  = ACKE;
    end else if (fall_i && (cnt_q == ACKE)) begin
      pull_d = 1'b0;
      pend_d = 1'b0;
      cnt_d  = '0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q  <= '0;
      sh_q   <= '0;
      pend_q <= 1'b0;
      pull_q <= 1'b0;
    end else begin
      cnt_q  <= cnt_d;
      sh_q   <= sh_d;
      pend_q <= pend_d;
      pull_q <= pull_d;
    end
  end

  assign byte_o     = {sh_q, sda_i};
  assign done_o     = !clr_i && rise_i && (cnt_q == LAST);
  assign boundary_o = (cnt_q <= CW'(1));
  assign pull_o     = pull_q;

  // R3
  ack_on_fall_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(pull_o) |-> $past(fall_i));
endmodule

// File: rtl/eew_page_buf.sv
module eew_page_buf #(
  parameter int DW  = 8,
  parameter int PAW = 3
) (
  input  logic                          clk,
  input  logic                          rst_n,
  input  logic                          clr_i,
  input  logic                          wr_i,
  input  logic [PAW-1:0]                idx_i,
  input  logic [DW-1:0]                 data_i,
  output logic [(1<<PAW)-1:0][DW-1:0]   data_o,
  output logic [(1<<PAW)-1:0]           valid_o
);
  localparam int PB = 1 << PAW;

  for (genvar g = 0; g < PB; g++) begin : g_slot
    logic          hit;
    logic [DW-1:0] val_q;
    logic          vld_q;

    assign hit = wr_i && (idx_i == PAW'(g));

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        val_q <= '0;
        vld_q <= 1'b0;
      end else if (clr_i) begin
        vld_q <= 1'b0;
      end else if (hit) begin
        val_q <= data_i;
        vld_q <= 1'b1;
      end
    end

    assign data_o[g]  = val_q;
    assign valid_o[g] = vld_q;
  end

  // R7
  last_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_i && !clr_i) |=> (valid_o[$past(idx_i)] && (data_o[$past(idx_i)] == $past(data_i))));
endmodule

// File: rtl/eew_mem_array.sv
module eew_mem_array #(
  parameter int AW  = 9,
  parameter int DW  = 8,
  parameter int PAW = 3
) (
  input  logic                          clk,
  input  logic                          rst_n,
  input  logic                          commit_i,
  input  logic [AW-PAW-1:0]             page_i,
  input  logic [(1<<PAW)-1:0][DW-1:0]   buf_data_i,
  input  logic [(1<<PAW)-1:0]           buf_valid_i,
  input  logic [AW-1:0]                 rd_addr_i,
  output logic [DW-1:0]                 rd_data_o
);
  localparam int DEPTH = 1 << AW;

  logic [DEPTH-1:0][DW-1:0] cells_w;

  for (genvar g = 0; g < DEPTH; g++) begin : g_cell
    localparam logic [AW-1:0] CA = AW'(g);
    logic          ld;
    logic [DW-1:0] c_q;

    assign ld = commit_i && (page_i == CA[AW-1:PAW]) && buf_valid_i[CA[PAW-1:0]];

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)  c_q <= '0;
      else if (ld) c_q <= buf_data_i[CA[PAW-1:0]];
    end

    assign cells_w[g] = c_q;
  end

  assign rd_data_o = cells_w[rd_addr_i];

  // R8
  mem_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !commit_i |=> $stable(cells_w));
endmodule

// File: rtl/i2c_eeprom_wr.sv
module i2c_eeprom_wr #(
  parameter logic [6:0] DEV_ADDR  = 7'h50,
  parameter int         MEM_AW    = 9,
  parameter int         PAGE_AW   = 3,
  parameter int         WR_CYCLES = 5000
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              scl_i,
  input  logic              sda_i,
  output logic              sda_pull_o,
  output logic              busy_o,
  input  logic [MEM_AW-1:0] rd_addr_i,
  output logic [7:0]        rd_data_o
);
  import eew_pkg::*;

  localparam int BYTE_W     = 8;
  localparam int HI_W       = MEM_AW - BYTE_W;
  localparam int PG_W       = MEM_AW - PAGE_AW;
  localparam int PAGE_BYTES = 1 << PAGE_AW;
  localparam int TW         = $clog2(WR_CYCLES);

  logic start_w, stop_w, rise_w, fall_w;
  logic [BYTE_W-1:0] rx_byte;
  logic rx_done, rx_bound, rx_pull, rx_clr;
  logic ack_req;

  eew_state_e state_q, state_d;
  logic [HI_W-1:0]   hi_q, hi_d;
  logic [PG_W-1:0]   page_q, page_d;
  logic [PAGE_AW-1:0] ptr_q, ptr_d;
  logic [TW-1:0]     tmr_q, tmr_d;
  logic [MEM_AW-1:0] addr_w;

  logic buf_wr, buf_clr, commit;
  logic [PAGE_BYTES-1:0][BYTE_W-1:0] buf_data;
  logic [PAGE_BYTES-1:0]             buf_valid;

  eew_bus_cond i_cond (
    .clk    (clk),
    .rst_n  (rst_n),
    .scl_i  (scl_i),
    .sda_i  (sda_i),
    .start_o(start_w),
    .stop_o (stop_w),
    .rise_o (rise_w),
    .fall_o (fall_w)
  );

  assign rx_clr = start_w | stop_w | (state_q == ST_BUSY);

  eew_byte_rx #(.BW(BYTE_W)) i_rx (
    .clk       (clk),
    .rst_n     (rst_n),
    .clr_i     (rx_clr),
    .rise_i    (rise_w),
    .fall_i    (fall_w),
    .sda_i     (sda_i),
    .ack_req_i (ack_req),
    .byte_o    (rx_byte),
    .done_o    (rx_done),
    .boundary_o(rx_bound),
    .pull_o    (rx_pull)
  );

  eew_page_buf #(.DW(BYTE_W), .PAW(PAGE_AW)) i_buf (
    .clk    (clk),
    .rst_n  (rst_n),
    .clr_i  (buf_clr),
    .wr_i   (buf_wr),
    .idx_i  (ptr_q),
    .data_i (rx_byte),
    .data_o (buf_data),
    .valid_o(buf_valid)
  );

  eew_mem_array #(.AW(MEM_AW), .DW(BYTE_W), .PAW(PAGE_AW)) i_mem (
    .clk        (clk),
    .rst_n      (rst_n),
    .commit_i   (commit),
    .page_i     (page_q),
    .buf_data_i (buf_data),
    .buf_valid_i(buf_valid),
    .rd_addr_i  (rd_addr_i),
    .rd_data_o  (rd_data_o)
  );

  assign addr_w = {hi_q, rx_byte};

  always_comb begin
    state_d = state_q;
    hi_d    = hi_q;
    page_d  = page_q;
    ptr_d   = ptr_q;
    tmr_d   = tmr_q;
    ack_req = 1'b0;
    buf_wr  = 1'b0;
    buf_clr = 1'b0;
    commit  = 1'b0;
    if (state_q == ST_BUSY) begin
      if (tmr_q == '0) begin
        commit  = 1'b1;
        buf_clr = 1'b1;
        state_d = ST_IDLE;
      end else begin
        tmr_d = tmr_q - 1'b1;
      end
    end else if (start_w) begin
      state_d = ST_DEV;
      buf_clr = 1'b1;
    end else if (stop_w) begin
      if ((state_q == ST_DATA) && rx_bound && (|buf_valid)) begin
        state_d = ST_BUSY;
        tmr_d   = TW'(WR_CYCLES - 1);
      end else begin
        state_d = ST_IDLE;
        buf_clr = 1'b1;
      end
    end else if (rx_done) begin
      unique case (state_q)
        ST_DEV: begin
          if ((rx_byte[7:1] == DEV_ADDR) && !rx_byte[0]) begin
            ack_req = 1'b1;
            state_d = ST_AHI;
          end else begin
            state_d = ST_SKIP;
          end
        end
        ST_AHI: begin
          ack_req = 1'b1;
          hi_d    = rx_byte[HI_W-1:0];
          state_d = ST_ALO;
        end
        ST_ALO: begin
          ack_req = 1'b1;
          page_d  = addr_w[MEM_AW-1:PAGE_AW];
          ptr_d   = addr_w[PAGE_AW-1:0];
          state_d = ST_DATA;
        end
        ST_DATA: begin
          ack_req = 1'b1;
          buf_wr  = 1'b1;
          ptr_d   = ptr_q + 1'b1;
        end
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      hi_q    <= '0;
      page_q  <= '0;
      ptr_q   <= '0;
      tmr_q   <= '0;
    end else begin
      state_q <= state_d;
      hi_q    <= hi_d;
      page_q  <= page_d;
      ptr_q   <= ptr_d;
      tmr_q   <= tmr_d;
    end
  end

  assign busy_o     = (state_q == ST_BUSY);
  assign sda_pull_o = rx_pull;

  // R8
  busy_from_stop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy_o) |-> $past(stop_w));

  // R10
  busy_has_data_chk: assert property (@(posedge clk) disable iff (!rst_n)
    busy_o |-> (|buf_valid));

  // R9
  busy_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    busy_o |-> !sda_pull_o);

  // R6
  page_base_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ((state_q == ST_DATA) && ($past(state_q) == ST_DATA)) |-> $stable(page_q));
endmodule

// File: tb/test_i2c_eeprom_wr.sv
module test_i2c_eeprom_wr;
  localparam logic [6:0] DEV   = 7'h2C;
  localparam int         AW    = 9;
  localparam int         WRC   = 600;
  localparam int         DEPTH = 1 << AW;
  localparam int         Q     = 3;

  // {addr16, length, seed}; data byte j = seed + 37*j
  localparam int NV = 5;
  localparam logic [31:0] VEC [NV] = '{
    {16'h0003, 8'd1,  8'h5A},
    {16'h0010, 8'd8,  8'h11},
    {16'h0125, 8'd6,  8'h80},
    {16'h0042, 8'd11, 8'hC3},
    {16'hFE1F, 8'd3,  8'h07}
  };

  logic clk, rst_n, scl_m, sda_m, sda_pull, busy;
  logic [AW-1:0] rd_addr;
  logic [7:0] rd_data;
  wire sda_line = sda_m & ~sda_pull;

  int checks, errors, busy_total;
  logic [7:0] model [DEPTH];

  i2c_eeprom_wr #(.DEV_ADDR(DEV), .MEM_AW(AW), .PAGE_AW(3), .WR_CYCLES(WRC)) i_i2c_eeprom_wr (
    .clk(clk), .rst_n(rst_n), .scl_i(scl_m), .sda_i(sda_line),
    .sda_pull_o(sda_pull), .busy_o(busy), .rd_addr_i(rd_addr), .rd_data_o(rd_data)
  );

  initial clk = 1'b0;
  always #2.5 clk = ~clk;

  initial busy_total = 0;
  always @(negedge clk) if (busy) busy_total <= busy_total + 1;

  task automatic chk(input bit ok, input string req, input string what, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic step();
    repeat (Q) @(negedge clk);
  endtask

  task automatic do_start();
    sda_m = 1'b1; step(); scl_m = 1'b1; step(); sda_m = 1'b0; step(); scl_m = 1'b0; step();
  endtask

  task automatic do_stop();
    sda_m = 1'b0; step(); scl_m = 1'b1; step(); sda_m = 1'b1; step();
  endtask

  task automatic send_bits(input logic [7:0] b, input int n);
    for (int i = 0; i < n; i++) begin
      sda_m = b[7-i]; step(); scl_m = 1'b1; step(); scl_m = 1'b0; step();
    end
  endtask

  task automatic send_byte(input logic [7:0] b, output bit ack);
    send_bits(b, 8);
    sda_m = 1'b1; step(); scl_m = 1'b1; step();
    ack = !sda_line;
    scl_m = 1'b0; step();
  endtask

  task automatic xfer(input logic [15:0] a, input int len, input logic [7:0] seed,
                      input bit stop_it, output int acks);
    bit ak;
    acks = 0;
    do_start();
    send_byte({DEV, 1'b0}, ak); acks += int'(ak);
    send_byte(a[15:8], ak);     acks += int'(ak);
    send_byte(a[7:0], ak);      acks += int'(ak);
    for (int j = 0; j < len; j++) begin
      send_byte(seed + 8'(j * 37), ak); acks += int'(ak);
    end
    if (stop_it) do_stop();
  endtask

  function automatic logic [AW-1:0] slot(input logic [15:0] a, input int j);
    return {a[AW-1:3], 3'(a[2:0] + 3'(j))};
  endfunction

  task automatic apply_model(input logic [15:0] a, input int len, input logic [7:0] seed);
    for (int j = 0; j < len; j++) model[slot(a, j)] = seed + 8'(j * 37);
  endtask

  task automatic mem_check(input string req, input string what);
    int bad, fa, fv, fe;
    bad = 0; fa = 0; fv = 0; fe = 0;
    for (int a = 0; a < DEPTH; a++) begin
      rd_addr = AW'(a);
      #1;
      if (rd_data !== model[a]) begin
        if (bad == 0) begin fa = a; fv = int'(rd_data); fe = int'(model[a]); end
        bad++;
      end
    end
    chk(bad == 0, req, $sformatf("%s memory at 0x%0h", what, fa), fv, fe);
  endtask

  task automatic wait_idle();
    for (int k = 0; k < WRC + 100 && busy; k++) @(negedge clk);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL R8 watchdog: actual %0d expected %0d", 1, 0);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    int acks, b0;
    bit ak;
    logic [15:0] a;
    int len;
    logic [7:0] seed;
    checks = 0; errors = 0;
    scl_m = 1'b1; sda_m = 1'b1; rd_addr = '0; rst_n = 1'b0;
    for (int i = 0; i < DEPTH; i++) model[i] = 8'h00;
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R11 reset state
    chk(busy == 1'b0, "R11", "busy after reset", int'(busy), 0);
    chk(sda_pull == 1'b0, "R11", "pull after reset", int'(sda_pull), 0);
    mem_check("R11", "reset");

    // R1 byte without a start is not acknowledged
    scl_m = 1'b0; step();
    send_byte({DEV, 1'b0}, ak);
    chk(ak == 1'b0, "R1", "ack without start", int'(ak), 0);
    do_stop();

    // table walk: R3 R4 R5 R6 R7 R8 R12
    for (int v = 0; v < NV; v++) begin
      a = VEC[v][31:16]; len = int'(VEC[v][15:8]); seed = VEC[v][7:0];
      b0 = busy_total;
      xfer(a, len, seed, 1'b1, acks);
      chk(acks == 3 + len, "R3", $sformatf("acks vector %0d", v), acks, 3 + len);
      rd_addr = slot(a, 0); #1;
      chk(busy && (rd_data == model[slot(a, 0)]), "R8",
          $sformatf("old data while busy vector %0d", v), int'(rd_data), int'(model[slot(a, 0)]));
      wait_idle();
      chk(busy_total - b0 == WRC, "R8", $sformatf("busy length vector %0d", v), busy_total - b0, WRC);
      apply_model(a, len, seed);
      mem_check(v == 0 ? "R5 R12" : (v == 3 ? "R7" : "R4 R6"), $sformatf("vector %0d", v));
    end

    // R2 wrong device address
    b0 = busy_total;
    do_start();
    send_byte({DEV ^ 7'h01, 1'b0}, ak);
    chk(ak == 1'b0, "R2", "ack for other device", int'(ak), 0);
    send_byte(8'h00, ak); acks = int'(ak);
    send_byte(8'h30, ak); acks += int'(ak);
    send_byte(8'hEE, ak); acks += int'(ak);
    do_stop();
    step();
    chk(acks == 0, "R2", "acks after mismatch", acks, 0);
    chk(busy_total == b0, "R2", "busy after mismatch", busy_total - b0, 0);
    mem_check("R2", "mismatch");

    // R2 read direction bit
    do_start();
    send_byte({DEV, 1'b1}, ak);
    chk(ak == 1'b0, "R2", "ack for read direction", int'(ak), 0);
    do_stop();

    // R10 stop with no data byte
    b0 = busy_total;
    xfer(16'h0050, 0, 8'h00, 1'b1, acks);
    step();
    chk(busy_total == b0, "R10", "busy without data", busy_total - b0, 0);

    // R10 stop in the middle of a byte
    b0 = busy_total;
    xfer(16'h0060, 2, 8'h99, 1'b0, acks);
    send_bits(8'hA5, 3);
    do_stop();
    step();
    chk(busy_total == b0, "R10", "busy after mid-byte stop", busy_total - b0, 0);
    mem_check("R10", "mid-byte stop");

    // R10 repeated start aborts, following write lands
    b0 = busy_total;
    xfer(16'h0070, 2, 8'h44, 1'b0, acks);
    xfer(16'h0078, 1, 8'h3C, 1'b1, acks);
    chk(acks == 4, "R10", "acks after repeated start", acks, 4);
    wait_idle();
    chk(busy_total - b0 == WRC, "R10", "single write interval", busy_total - b0, WRC);
    apply_model(16'h0078, 1, 8'h3C);
    mem_check("R10", "repeated start");

    // R9 traffic during busy is ignored
    b0 = busy_total;
    xfer(16'h0180, 1, 8'h21, 1'b1, acks);
    xfer(16'h0188, 1, 8'h77, 1'b1, acks);
    chk(acks == 0, "R9", "acks while busy", acks, 0);
    chk(busy == 1'b1, "R9", "still busy after ignored write", int'(busy), 1);
    wait_idle();
    chk(busy_total - b0 == WRC, "R9", "interval not extended", busy_total - b0, WRC);
    apply_model(16'h0180, 1, 8'h21);
    mem_check("R9", "busy ignore");

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule